// File: doc/BRIEF.md
# Packet Completion Interrupt Coalescer

This unit sits beside one channel of a descriptor-driven DMA engine and thins out its completion interrupts. A down-counter is preset to a programmable batch size and counts finished packets. When the last packet of a batch arrives it raises a sticky completion flag and presets itself again. A delay timer runs alongside the counter. Every finished packet restarts it from a programmable value. If it runs out before the next packet arrives, it raises a sticky timeout flag and presets the packet counter, so a partial batch is closed off and no stale count is left behind.

The batch size and delay come from fields of the channel's control word. The unit captures them whenever the surrounding register logic strobes a control write. The live packet count and timer value are outputs, so the status register can show them. The timer advances on an enable pulse from an internal prescaler, which divides the core clock down to the timer reference rate. Each flag stays set until its own clear strobe arrives.

Top module: `coal_irq_timer`

## Requirements
- R1: After reset, `irq_cmpl` and `irq_dly` are 0, `pkt_left` is 1 (batch size resets to 1) and `dly_left` is 0 (delay resets to 0).
- R2: A `ctrl_wr` pulse does three things. It captures the batch size from `ctrl_word[23:16]` and the delay from `ctrl_word[31:24]`. It presets `pkt_left` to the new batch size on the same edge. If `pkt_done` or a timer expiry falls in the same cycle, the preset from `ctrl_wr` wins.
- R3: A `pkt_done` pulse that does not end a batch lowers `pkt_left` by exactly one on that edge.
- R4: A `pkt_done` pulse seen while `pkt_left` is 1 does two things on that edge. It sets `irq_cmpl` and presets `pkt_left` to the batch size.
- R5: A `pkt_done` pulse with a nonzero delay loads `dly_left` with the delay and restarts the prescaler. With a delay of 0, `pkt_done` leaves `dly_left` unchanged.
- R6: While nonzero, `dly_left` falls by one every DIV core cycles, where DIV = CLK_HZ / TICK_HZ. It counts from the edge that loaded it, so after a load of D it reaches 0 on the D*DIV-th following edge. At 0 it holds.
- R7: When `dly_left` steps from 1 to 0, the same edge sets `irq_dly` and presets `pkt_left` to the batch size. A `pkt_done` that restarts the timer in that cycle cancels the expiry.
- R8: With a delay of 0, the timer never starts, so `irq_dly` is never set.
- R9: Each flag stays set until its clear strobe (`clr_cmpl`, `clr_dly`). If a set and a clear land in the same cycle, the flag ends up set.
- R10: A `ctrl_wr` pulse changes neither `dly_left` nor either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word; batch size in bits 23:16, delay in bits 31:24 |
| ctrl_wr | input | 1 | One-cycle strobe: control word written |
| pkt_done | input | 1 | One-cycle pulse per finished packet |
| clr_cmpl | input | 1 | Clear strobe for the completion flag |
| clr_dly | input | 1 | Clear strobe for the timeout flag |
| irq_cmpl | output | 1 | Sticky batch-complete flag |
| irq_dly | output | 1 | Sticky timeout flag |
| pkt_left | output | 8 | Packets left in the current batch |
| dly_left | output | 8 | Remaining delay ticks |

## Verification
The bench builds the unit with CLK_HZ = 125_000_000 and TICK_HZ = 31_250_000, which gives a divide ratio of 4. With that ratio the bench can check a cycle-exact step between timer decrements, including the core cycles in which the timer must not move. It can also see a control write land between ticks and leave the timer alone. The 8-bit count and delay widths are kept, so the field positions in the control word are the ones a real register decoder would drive. Small batch sizes (1, 3, 4) and delays (3, 5) keep the batch-boundary and expiry edges short enough to test one by one.

// File: rtl/coal_pkg.sv
// Shared constants for the interrupt coalescer.
// Assumes the clock rates are given in Hz and that CLK_HZ >= TICK_HZ.
package coal_pkg;

    localparam int unsigned DEF_CLK_HZ  = 100_000_000;
    localparam int unsigned DEF_TICK_HZ = 50_000_000;

    // Core cycles per timer tick, never below 1.
    function automatic int unsigned tick_div(input int unsigned clk_hz,
                                             input int unsigned tick_hz);
        int unsigned d;
        d = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
        return (d == 0) ? 1 : d;
    endfunction

endpackage

// File: rtl/coal_prescaler.sv
// Produces a one-cycle tick enable every DIV core cycles.
// A restart zeroes the phase, so the first tick arrives DIV cycles later.
// Assumes DIV >= 1; with DIV == 1 the tick is asserted every cycle.
module coal_prescaler #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] phase;

            // Phase counter: wraps at DIV-1, zeroed on restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart)
                    phase <= '0;
                else if (phase == PW'(DIV - 1))
                    phase <= '0;
                else
                    phase <= phase + 1'b1;
            end

            assign tick = (phase == PW'(DIV - 1));

            a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/coal_delay_timer.sv
// Down-counting delay timer. A load presets it. Each tick lowers it by one
// while it is nonzero, and it holds at zero. Expiry is a one-cycle pulse for
// the step from 1 to 0, and a load in the same cycle cancels it.
module coal_delay_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    // Timer register: load first, otherwise step down on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = tick && !load && (cnt == W'(1));

    a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> cnt == '0);
    a_r6_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

endmodule

// File: rtl/coal_pkt_counter.sv
// Batch counter: counts finished packets down and presets itself from the
// batch size at the end of a batch or on an external reload. A reload beats
// a packet in the same cycle. Reset value is RST_VAL.
module coal_pkt_counter #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         dec,
    input  logic [W-1:0] thr,
    output logic [W-1:0] cnt,
    output logic         hit
);
    assign hit = dec && !reload && (cnt == W'(1));

    // Count register: reload, batch end, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (reload || hit)
            cnt <= thr;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !reload && cnt != W'(1)) |=> cnt == $past(cnt) - 1'b1);
    a_r4_batch_end: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cnt == $past(thr));

endmodule

// File: rtl/coal_sticky_flag.sv
// Sticky interrupt flag: set wins over a clear in the same cycle.
module coal_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);

endmodule

// File: rtl/coal_irq_timer.sv
// Per-channel interrupt coalescer: batch counter, delay timer, prescaler
// and two sticky flags. Batch size and delay are captured from the control
// word on a control write. Assumes ctrl_wr, pkt_done and the clears are
// one-cycle strobes from logic synchronous to clk.
module coal_irq_timer
    import coal_pkg::*;
#(
    parameter int unsigned CLK_HZ  = DEF_CLK_HZ,
    parameter int unsigned TICK_HZ = DEF_TICK_HZ,
    parameter int unsigned CTRL_W  = 32,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DLY_W   = 8,
    parameter int unsigned THR_LSB = 16,
    parameter int unsigned DLY_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              ctrl_wr,
    input  logic              pkt_done,
    input  logic              clr_cmpl,
    input  logic              clr_dly,
    output logic              irq_cmpl,
    output logic              irq_dly,
    output logic [CNT_W-1:0]  pkt_left,
    output logic [DLY_W-1:0]  dly_left
);
    localparam int unsigned DIV = tick_div(CLK_HZ, TICK_HZ);

    logic [CNT_W-1:0] thr_q, thr_eff;
    logic [DLY_W-1:0] dly_q, dly_eff;
    logic             tick, tmr_load, expire, batch_hit;

    // Captured batch size and delay; batch size resets to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= CNT_W'(1);
            dly_q <= '0;
        end else if (ctrl_wr) begin
            thr_q <= ctrl_word[THR_LSB +: CNT_W];
            dly_q <= ctrl_word[DLY_LSB +: DLY_W];
        end
    end

    // Settings in force this cycle, counting a write now in progress.
    always_comb begin
        thr_eff = ctrl_wr ? ctrl_word[THR_LSB +: CNT_W] : thr_q;
        dly_eff = ctrl_wr ? ctrl_word[DLY_LSB +: DLY_W] : dly_q;
    end

    assign tmr_load = pkt_done && (dly_eff != '0);

    coal_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(tmr_load), .tick(tick)
    );

    coal_delay_timer #(.W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
        .load_val(dly_eff), .cnt(dly_left), .expire(expire)
    );

    coal_pkt_counter #(.W(CNT_W), .RST_VAL(1)) u_count (
        .clk(clk), .rst_n(rst_n), .reload(ctrl_wr || expire),
        .dec(pkt_done), .thr(thr_eff), .cnt(pkt_left), .hit(batch_hit)
    );

    coal_sticky_flag u_flag_cmpl (
        .clk(clk), .rst_n(rst_n), .set(batch_hit), .clr(clr_cmpl), .q(irq_cmpl)
    );

    coal_sticky_flag u_flag_dly (
        .clk(clk), .rst_n(rst_n), .set(expire), .clr(clr_dly), .q(irq_dly)
    );

    a_r2_ctrl_preset: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> pkt_left == $past(ctrl_word[THR_LSB +: CNT_W]));
    a_r7_expiry_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl_wr) |=> (pkt_left == $past(thr_q)) && irq_dly);
    a_r8_no_delay_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_left == '0 && !tmr_load && !irq_dly) |=> !irq_dly);
    a_r10_ctrl_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && irq_cmpl && irq_dly && !clr_cmpl && !clr_dly) |=> irq_cmpl && irq_dly);

endmodule

// File: tb/coal_irq_timer_test.sv
module coal_irq_timer_test;
    localparam int unsigned CLK_HZ  = 125_000_000;
    localparam int unsigned TICK_HZ = 31_250_000;
    localparam int          DIV     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        ctrl_wr = 1'b0, pkt_done = 1'b0, clr_cmpl = 1'b0, clr_dly = 1'b0;
    logic        irq_cmpl, irq_dly;
    logic [7:0]  pkt_left, dly_left;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    coal_irq_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl_wr(ctrl_wr),
        .pkt_done(pkt_done), .clr_cmpl(clr_cmpl), .clr_dly(clr_dly),
        .irq_cmpl(irq_cmpl), .irq_dly(irq_dly),
        .pkt_left(pkt_left), .dly_left(dly_left)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int thr, input int dly);
        return {8'(dly), 8'(thr), 16'h0000};
    endfunction

    // Drive one-cycle strobes just after a falling edge; return at the next one.
    task automatic strobe(input logic w, input logic [31:0] word, input logic p,
                          input logic cc, input logic cd);
        ctrl_word = word; ctrl_wr = w; pkt_done = p; clr_cmpl = cc; clr_dly = cd;
        @(negedge clk);
        ctrl_wr = 1'b0; pkt_done = 1'b0; clr_cmpl = 1'b0; clr_dly = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq_cmpl", irq_cmpl, 0);
        chk("R1 irq_dly", irq_dly, 0);
        chk("R1 pkt_left", pkt_left, 1);
        chk("R1 dly_left", dly_left, 0);
    endtask

    task automatic t_batch();
        strobe(1, cw(3, 0), 0, 0, 0);
        chk("R2 preset", pkt_left, 3);
        strobe(0, '0, 1, 0, 0);
        chk("R3 dec to 2", pkt_left, 2);
        chk("R4 no flag mid-batch", irq_cmpl, 0);
        strobe(0, '0, 1, 0, 0);
        chk("R3 dec to 1", pkt_left, 1);
        strobe(0, '0, 1, 0, 0);
        chk("R4 flag at batch end", irq_cmpl, 1);
        chk("R4 preset at batch end", pkt_left, 3);
        chk("R5 delay 0 leaves timer", dly_left, 0);
        repeat (40) @(negedge clk);
        chk("R8 no timeout with delay 0", irq_dly, 0);
    endtask

    task automatic t_flags();
        repeat (3) @(negedge clk);
        chk("R9 sticky", irq_cmpl, 1);
        strobe(0, '0, 0, 1, 0);
        chk("R9 clear", irq_cmpl, 0);
        strobe(1, cw(1, 0), 0, 0, 0);
        strobe(0, '0, 1, 1, 0);
        chk("R9 set beats clear", irq_cmpl, 1);
        strobe(0, '0, 0, 1, 0);
        chk("R9 clear again", irq_cmpl, 0);
    endtask

    task automatic t_delay();
        strobe(1, cw(4, 3), 0, 0, 0);
        strobe(0, '0, 1, 0, 0);
        chk("R5 timer loaded", dly_left, 3);
        chk("R3 count 3", pkt_left, 3);
        repeat (3) @(negedge clk);
        chk("R6 no step before DIV", dly_left, 3);
        @(negedge clk);
        chk("R6 step after DIV", dly_left, 2);
        repeat (7) @(negedge clk);
        chk("R6 one before expiry", dly_left, 1);
        chk("R7 flag not yet", irq_dly, 0);
        @(negedge clk);
        chk("R7 timeout flag", irq_dly, 1);
        chk("R7 count preset", pkt_left, 4);
        chk("R6 reaches 0", dly_left, 0);
        repeat (10) @(negedge clk);
        chk("R6 holds 0", dly_left, 0);
    endtask

    task automatic t_restart();
        strobe(0, '0, 1, 0, 0);
        repeat (5) @(negedge clk);
        chk("R6 mid-run", dly_left, 2);
        strobe(0, '0, 1, 0, 0);
        chk("R5 restart reloads", dly_left, 3);
        chk("R3 count after 2 pkts", pkt_left, 2);
        strobe(1, cw(4, 5), 0, 0, 0);
        chk("R10 timer kept", dly_left, 3);
        chk("R10 timeout flag kept", irq_dly, 1);
        chk("R2 preset on write", pkt_left, 4);
        repeat (40) @(negedge clk);
        chk("R7 second expiry", dly_left, 0);
        strobe(0, '0, 0, 0, 1);
        chk("R9 clear timeout", irq_dly, 0);
    endtask

    task automatic t_priority();
        strobe(1, cw(2, 0), 0, 0, 0);
        strobe(0, '0, 1, 0, 0);
        chk("R5 delay 0 after expiry", dly_left, 0);
        strobe(1, cw(6, 0), 1, 0, 0);
        chk("R2 write beats packet", pkt_left, 6);
        chk("R2 no flag from dropped pkt", irq_cmpl, 0);
        repeat (20) @(negedge clk);
        chk("R8 still no timeout", irq_dly, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_batch();
        t_flags();
        t_delay();
        t_restart();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule